// File: doc/BRIEF.md
# Serial Stereo Sample Receiver

This block takes the bit-serial stereo stream that a disc signal processor emits and turns it into parallel sample pairs. The serial side carries four wires: a bit clock, a channel-select clock whose level names the channel, a data line, and an error pointer that marks damaged bytes. All four are brought into a faster system clock through two-flop synchronisers. The active bit-clock edge is then detected in the system domain, and each bit is shifted into a word register.

Three settings shape reception. A two-bit slot code gives the number of bit clocks in each channel half. A bit-order flag picks whether the most or the least significant bit arrives first. An edge flag picks whether lines are sampled on the rising or the falling bit-clock edge. In the longer slots the 16 data bits sit at the end of each half, and the bits before them carry no meaning. When a right word completes, the block presents the left and right words together with four byte error flags and a one-cycle valid strobe.

Top module: `cdPcmRx`

## Requirements
- R1: While rstN is low, leftWord, rightWord and errFlags read zero and pairValid is low. A reset in the middle of a stream returns the block to this state.
- R2: slotMode 2'b00, 2'b01 and 2'b10 give 16, 24 and 32 bit clocks per channel half. The word is taken from the last 16 bit positions of each half, counted from the first bit after the channel clock changes. Data and error-pointer values in the earlier positions have no effect.
- R3: With lsbFirst = 0, the first data bit of a half is word bit 15 and the last data bit is bit 0.
- R4: With lsbFirst = 1, the first data bit of a half is word bit 0 and the last data bit is bit 15.
- R5: lrClkIn high marks the left channel and low marks the right channel. A channel word ends at each change of the sampled lrClkIn. The half in progress at reset is discarded. A pair is produced only when a complete left half has been followed by a complete right half.
- R6: errFlags is {left upper byte, left lower byte, right upper byte, right lower byte}, from bit 3 down to bit 0. A flag is set when errIn is sampled high on any data bit that belongs to that byte, where the upper byte holds word bits 15..8.
- R7: edgeSel = 0 samples lrClkIn, dataIn and errIn on the rising bit-clock edge, and edgeSel = 1 samples them on the falling edge. The other edge is ignored.
- R8: pairValid is a single-cycle pulse. It rises at the third system clock edge after the bit-clock sampling edge of the first bit of the next left half. The output words and flags hold their values between pulses.
- R9: Bit positions beyond the selected half length are ignored, so a half that runs longer than the slot code allows keeps the word taken from its first positions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8 times the bit clock |
| rstN | input | 1 | Asynchronous active-low reset |
| bitClkIn | input | 1 | Serial bit clock, asynchronous |
| lrClkIn | input | 1 | Channel clock, high for left |
| dataIn | input | 1 | Serial data line |
| errIn | input | 1 | Serial error pointer |
| slotMode | input | 2 | Half-slot length: 00=16, 01=24, 10=32 bit clocks |
| lsbFirst | input | 1 | 1 selects least significant bit first |
| edgeSel | input | 1 | 1 selects the falling bit-clock edge for sampling |
| leftWord | output | 16 | Left sample of the latest pair |
| rightWord | output | 16 | Right sample of the latest pair |
| errFlags | output | 4 | Byte error flags of the latest pair |
| pairValid | output | 1 | One-cycle strobe when a new pair is presented |

## Verification
Each pair is due at the third system clock edge after the bit-clock sampling edge that opens the next left half: two synchroniser stages, then the output register. The driver stores the system cycle in which it makes each sampling edge. The monitor compares the cycle in which it sees pairValid against that value plus three, and compares the words and flags against the scoreboard entry the driver queued for that frame. Reset values are sampled after several cycles with rstN low, well after the asynchronous clear.

// File: rtl/cdPcmRxPkg.sv
package cdPcmRxPkg;

  // Strobes passed from the serial control to the word datapath.
  typedef struct packed {
    logic shiftEn;      // a data bit inside the window was sampled
    logic restart;      // the channel clock changed on this sample
    logic upperHalf;    // the sampled bit belongs to the upper byte
    logic bitVal;       // synchronised data value
    logic errVal;       // synchronised error-pointer value
    logic commitLeft;   // the left word just ended
    logic commitRight;  // the right word just ended after a full left word
  } rxStrobe_t;

endpackage

// File: rtl/pcmRxSync.sv
module pcmRxSync #(
  parameter int WIDTH  = 4,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  logic [STAGES-1:0][WIDTH-1:0] pipe;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pipe[0] <= '0;
    else       pipe[0] <= din;
  end

  generate
    for (genvar s = 1; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) pipe[s] <= '0;
        else       pipe[s] <= pipe[s-1];
      end
    end
  endgenerate

  assign dout = pipe[STAGES-1];

endmodule

// File: rtl/pcmRxCtrl.sv
module pcmRxCtrl
  import cdPcmRxPkg::*;
#(
  parameter int DATA_W      = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       bitClkIn,
  input  logic       lrClkIn,
  input  logic       dataIn,
  input  logic       errIn,
  input  logic [1:0] slotMode,
  input  logic       lsbFirst,
  input  logic       edgeSel,
  output rxStrobe_t  strobe
);

  localparam int IDX_W   = $clog2(2 * DATA_W) + 1;
  localparam int HALF_W  = DATA_W / 2;
  localparam logic [IDX_W-1:0] IDX_MAX = '1;

  logic [3:0] syncOut;
  logic       bckS, lrS, datS, errS;
  logic       bckPrev;
  logic       sampleEn;
  logic       seen, locked, lrLast, leftHave;
  logic [IDX_W-1:0] bitIdx, curIdx, halfLen, winStart, dataPos;
  logic       lrChange, inWindow, firstHalf;

  pcmRxSync #(.WIDTH(4), .STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rstN (rstN),
    .din  ({bitClkIn, lrClkIn, dataIn, errIn}),
    .dout (syncOut)
  );

  assign bckS = syncOut[3];
  assign lrS  = syncOut[2];
  assign datS = syncOut[1];
  assign errS = syncOut[0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) bckPrev <= 1'b0;
    else       bckPrev <= bckS;
  end

  // Active edge of the synchronised bit clock.
  always_comb begin
    if (edgeSel) sampleEn = bckPrev & ~bckS;
    else         sampleEn = ~bckPrev & bckS;
  end

  // Half-slot length from the slot code; the spare code acts as the longest.
  always_comb begin
    case (slotMode)
      2'b00:   halfLen = IDX_W'(DATA_W);
      2'b01:   halfLen = IDX_W'(DATA_W + HALF_W);
      default: halfLen = IDX_W'(2 * DATA_W);
    endcase
    winStart = halfLen - IDX_W'(DATA_W);
  end

  assign lrChange  = sampleEn & seen & (lrS != lrLast);
  assign curIdx    = lrChange ? '0 : bitIdx;
  assign inWindow  = (locked | lrChange) & (curIdx >= winStart) & (curIdx < halfLen);
  assign dataPos   = curIdx - winStart;
  assign firstHalf = dataPos < IDX_W'(HALF_W);

  always_comb begin
    strobe.shiftEn     = sampleEn & inWindow;
    strobe.restart     = lrChange;
    strobe.upperHalf   = lsbFirst ? ~firstHalf : firstHalf;
    strobe.bitVal      = datS;
    strobe.errVal      = errS;
    strobe.commitLeft  = lrChange & locked & lrLast;
    strobe.commitRight = lrChange & locked & ~lrLast & leftHave;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      seen     <= 1'b0;
      locked   <= 1'b0;
      lrLast   <= 1'b0;
      leftHave <= 1'b0;
      bitIdx   <= '0;
    end else if (sampleEn) begin
      seen   <= 1'b1;
      lrLast <= lrS;
      bitIdx <= (curIdx == IDX_MAX) ? curIdx : curIdx + 1'b1;
      if (lrChange) locked <= 1'b1;
      if (strobe.commitLeft)       leftHave <= 1'b1;
      else if (strobe.commitRight) leftHave <= 1'b0;
    end
  end

endmodule

// File: rtl/pcmRxData.sv
module pcmRxData
  import cdPcmRxPkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  rxStrobe_t         strobe,
  input  logic              lsbFirst,
  output logic [DATA_W-1:0] leftWord,
  output logic [DATA_W-1:0] rightWord,
  output logic [3:0]        errFlags,
  output logic              pairValid
);

  logic [DATA_W-1:0] shReg, shBase, shNext, leftHold;
  logic [1:0]        acc, accBase, accNext, leftErrHold;

  always_comb begin
    shBase = strobe.restart ? '0 : shReg;
    if (!strobe.shiftEn)  shNext = shBase;
    else if (lsbFirst)    shNext = {strobe.bitVal, shBase[DATA_W-1:1]};
    else                  shNext = {shBase[DATA_W-2:0], strobe.bitVal};

    accBase = strobe.restart ? 2'b00 : acc;
    accNext = accBase;
    if (strobe.shiftEn && strobe.errVal) begin
      if (strobe.upperHalf) accNext[1] = 1'b1;
      else                  accNext[0] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shReg       <= '0;
      acc         <= '0;
      leftHold    <= '0;
      leftErrHold <= '0;
      leftWord    <= '0;
      rightWord   <= '0;
      errFlags    <= '0;
      pairValid   <= 1'b0;
    end else begin
      shReg     <= shNext;
      acc       <= accNext;
      pairValid <= strobe.commitRight;
      if (strobe.commitLeft) begin
        leftHold    <= shReg;
        leftErrHold <= acc;
      end
      if (strobe.commitRight) begin
        leftWord  <= leftHold;
        rightWord <= shReg;
        errFlags  <= {leftErrHold, acc};
      end
    end
  end

endmodule

// File: rtl/cdPcmRx.sv
module cdPcmRx
  import cdPcmRxPkg::*;
#(
  parameter int DATA_W      = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              bitClkIn,
  input  logic              lrClkIn,
  input  logic              dataIn,
  input  logic              errIn,
  input  logic [1:0]        slotMode,
  input  logic              lsbFirst,
  input  logic              edgeSel,
  output logic [DATA_W-1:0] leftWord,
  output logic [DATA_W-1:0] rightWord,
  output logic [3:0]        errFlags,
  output logic              pairValid
);

  rxStrobe_t strobe;

  pcmRxCtrl #(.DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .bitClkIn (bitClkIn),
    .lrClkIn  (lrClkIn),
    .dataIn   (dataIn),
    .errIn    (errIn),
    .slotMode (slotMode),
    .lsbFirst (lsbFirst),
    .edgeSel  (edgeSel),
    .strobe   (strobe)
  );

  pcmRxData #(.DATA_W(DATA_W)) u_data (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .lsbFirst  (lsbFirst),
    .leftWord  (leftWord),
    .rightWord (rightWord),
    .errFlags  (errFlags),
    .pairValid (pairValid)
  );

endmodule

// File: rtl/cdPcmRxChk.sv
module cdPcmRxChk
  import cdPcmRxPkg::*;
(
  input logic      clk,
  input logic      rstN,
  input rxStrobe_t strobe,
  input logic      pairValid,
  input logic [15:0] leftWord,
  input logic [15:0] rightWord,
  input logic [3:0]  errFlags
);

  // R8
  pair_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    pairValid |=> !pairValid);

  // R8
  hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !pairValid |-> ($stable(leftWord) && $stable(rightWord) && $stable(errFlags)));

  // R8
  commit_to_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.commitRight |=> pairValid);

  // R5
  one_commit_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(strobe.commitLeft && strobe.commitRight));

  // R7
  sample_spacing_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.shiftEn || strobe.restart) |=> !(strobe.shiftEn || strobe.restart));

  // R5
  restart_commit_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.commitLeft || strobe.commitRight) |-> strobe.restart);

endmodule

bind cdPcmRx cdPcmRxChk u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .strobe    (strobe),
  .pairValid (pairValid),
  .leftWord  (leftWord),
  .rightWord (rightWord),
  .errFlags  (errFlags)
);

// File: tb/tb_cdPcmRx.sv
module tb_cdPcmRx;

  localparam int HALF = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic bck = 1'b0, lr = 1'b0, dat = 1'b0, err = 1'b0;
  logic [1:0] mode = 2'b00;
  logic lsbF = 1'b0, edgeS = 1'b0;
  logic [15:0] leftWord, rightWord;
  logic [3:0]  errFlags;
  logic        pairValid;

  typedef struct {
    logic [15:0] l;
    logic [15:0] r;
    logic [3:0]  f;
    string       tag;
  } exp_t;

  exp_t expQ[$];
  exp_t monE;
  int checks = 0, fails = 0, cyc = 0, edgeCyc = 0;
  bit done = 0;

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  cdPcmRx dut (
    .clk(clk), .rstN(rstN), .bitClkIn(bck), .lrClkIn(lr), .dataIn(dat),
    .errIn(err), .slotMode(mode), .lsbFirst(lsbF), .edgeSel(edgeS),
    .leftWord(leftWord), .rightWord(rightWord), .errFlags(errFlags),
    .pairValid(pairValid)
  );

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, expv);
    end
  endtask

  function automatic logic gb(input int i);
    return ((i * 5 + 3) % 7) < 3;
  endfunction

  task automatic sendBit(input logic l, input logic d, input logic e);
    @(negedge clk);
    bck = edgeS; lr = l; dat = d; err = e;
    repeat (HALF) @(negedge clk);
    bck = ~edgeS;
    edgeCyc = cyc;
    repeat (HALF - 1) @(negedge clk);
  endtask

  // Data at positions ws..ws+15, junk data with errIn high elsewhere.
  task automatic sendHalf(input logic l, input int len, input int ws,
                          input logic [15:0] w, input logic eHi, input logic eLo);
    for (int i = 0; i < len; i++) begin
      if (i >= ws && i < ws + 16) begin
        int k = i - ws;
        int b = lsbF ? k : 15 - k;
        sendBit(l, w[b], (b >= 8) ? eHi : eLo);
      end else begin
        sendBit(l, gb(i), 1'b1);
      end
    end
  endtask

  task automatic frame(input logic [15:0] lw, input logic [15:0] rw,
                       input logic [1:0] lf, input logic [1:0] rf,
                       input int len, input int ws, input string tag);
    exp_t e;
    e.l = lw; e.r = rw; e.f = {lf, rf}; e.tag = tag;
    expQ.push_back(e);
    sendHalf(1'b1, len, ws, lw, lf[1], lf[0]);
    sendHalf(1'b0, len, ws, rw, rf[1], rf[0]);
  endtask

  task automatic startGroup(input logic [1:0] m, input logic lsb, input logic ed);
    @(negedge clk);
    rstN = 1'b0; mode = m; lsbF = lsb; edgeS = ed; bck = ed; lr = 1'b0;
    repeat (4) @(negedge clk);
    // R1 reset state
    check(leftWord == 16'h0, "R1", "leftWord in reset", 32'(leftWord), 32'h0);
    check(rightWord == 16'h0, "R1", "rightWord in reset", 32'(rightWord), 32'h0);
    check(errFlags == 4'h0, "R1", "errFlags in reset", 32'(errFlags), 32'h0);
    check(pairValid == 1'b0, "R1", "pairValid in reset", 32'(pairValid), 32'h0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic flush();
    sendBit(1'b1, 1'b0, 1'b0);
    sendBit(1'b1, 1'b0, 1'b0);
    repeat (8) @(negedge clk);
  endtask

  // Scoreboard monitor
  always @(negedge clk) begin
    if (rstN && pairValid) begin
      if (expQ.size() == 0) begin
        check(1'b0, "R5", "unexpected pair", 32'(leftWord), 32'h0);
      end else begin
        monE = expQ.pop_front();
        check(leftWord == monE.l, monE.tag, "leftWord", 32'(leftWord), 32'(monE.l));
        check(rightWord == monE.r, monE.tag, "rightWord", 32'(rightWord), 32'(monE.r));
        check(errFlags == monE.f, "R6", "errFlags", 32'(errFlags), 32'(monE.f));
        // R8 pair latency from the opening sampling edge
        check(cyc - edgeCyc == 3, "R8", "latency", 32'(cyc - edgeCyc), 32'd3);
      end
    end
  end

  initial begin
    // R2 R3 R5: 16-bit halves, MSB first, rising edge
    startGroup(2'b00, 1'b0, 1'b0);
    sendHalf(1'b0, 16, 0, 16'h5A5A, 1'b0, 1'b0);
    frame(16'hA5C3, 16'h1234, 2'b00, 2'b00, 16, 0, "R3");
    frame(16'hFFFF, 16'h0000, 2'b10, 2'b01, 16, 0, "R2");
    flush();

    // R4 R2: 24-bit halves, LSB first, junk ahead of data ignored
    startGroup(2'b01, 1'b1, 1'b0);
    sendHalf(1'b0, 24, 8, 16'h0F0F, 1'b0, 1'b0);
    frame(16'h8001, 16'h7E35, 2'b01, 2'b11, 24, 8, "R4");
    frame(16'h00FF, 16'hC0DE, 2'b00, 2'b00, 24, 8, "R4");
    flush();

    // R7 R2: 32-bit halves, MSB first, falling edge
    startGroup(2'b10, 1'b0, 1'b1);
    sendHalf(1'b0, 32, 16, 16'h3333, 1'b0, 1'b0);
    frame(16'hBEEF, 16'h4C1D, 2'b11, 2'b10, 32, 16, "R7");
    frame(16'h0001, 16'h8000, 2'b00, 2'b00, 32, 16, "R7");
    flush();

    // R9: 16-bit code, 24-bit halves with data first
    startGroup(2'b00, 1'b0, 1'b0);
    sendHalf(1'b0, 24, 0, 16'h1111, 1'b0, 1'b0);
    frame(16'h6B2E, 16'h9D04, 2'b00, 2'b01, 24, 0, "R9");
    flush();

    // R5: stream opens inside a left half; no pair from partial data
    startGroup(2'b00, 1'b0, 1'b0);
    sendHalf(1'b1, 16, 0, 16'hDEAD, 1'b1, 1'b1);
    sendHalf(1'b0, 16, 0, 16'hF00D, 1'b1, 1'b1);
    frame(16'h2468, 16'h1357, 2'b01, 2'b00, 16, 0, "R5");
    flush();

    // R8 R5: every queued pair was produced, none left over
    check(expQ.size() == 0, "R8", "pending pairs", 32'(expQ.size()), 32'd0);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule